// File: doc/BRIEF.md
# Capture and Bi-Value Down Counter

A two-channel 16-bit down counter. Each channel has its own 8-bit clock prescaler, a primary reload constant and a capture register. In internal mode a channel steps down once per prescaler tick. On the tick that finds it at zero it reloads and gives a one-cycle terminal-count pulse. A rising edge on the channel's capture pin, or a software capture strobe, copies the live count into the capture register. The pin is first passed through a two-flop synchronizer.

In bi-value mode the capture register stops taking captures and serves as a second reload constant. Reloads then alternate, starting from the primary constant. With cascade enabled, the two channels form one 32-bit count. Channel 1's prescaler is the only one running, and it clocks channel 0. Channel 0's reload event is the count enable for channel 1.

Each channel has a three-state controller:
- STOP holds the count and keeps the prescaler cleared.
- LOAD waits for the first tick and then loads the first constant.
- RUN counts down and reloads.

The transitions are:
- STOP→LOAD: a control write with the run bit set.
- LOAD→RUN: the first tick.
- LOAD→STOP and RUN→STOP: a control write with the run bit clear.

Top module: `capbi_timer`

## Requirements
- R1: After reset both channels are in STOP. The counts, the capture registers, the constants and the terminal-count outputs are zero. The prescale select is 000, bi-value mode is off, cascade takes effect only through `cascade_en`, and the next bi-value reload is taken from the primary constant.
- R2: A running channel's prescaler ticks once every 2^(s+1) clocks, where s is the 3-bit select: 000 gives /2 and 111 gives /256. The prescaler is cleared while its channel is stopped.
- R3: A control write with bit 0 (run) set moves a stopped channel to LOAD. Its first tick loads the reload constant, and each later tick in RUN lowers a nonzero count by one. A control write with run clear stops the channel and freezes its count.
- R4: A tick in RUN that finds the count at zero reloads the count. On the same edge, `tc` rises for exactly one cycle. A constant K gives a period of K+1 ticks.
- R5: The capture pin passes through two flops. A rising edge found after the synchronizer copies the count into the capture register, which holds it until the next capture or write.
- R6: A `sw_cap` pulse captures the count in the same way. When a pin edge and a software strobe fall in the same cycle, they make a single capture.
- R7: With control bit 1 (bi-value) set, reloads alternate between the primary constant and the capture register, beginning with the primary constant. Clearing bi-value resets the alternation to the primary constant.
- R8: In bi-value mode, pin edges and software strobes leave the capture register unchanged.
- R9: With `cascade_en` high:
  - channel 0 ticks on channel 1's prescaler, using channel 1's select;
  - channel 0's own prescaler is held cleared;
  - channel 1 ticks once on each channel 0 reload.
- R10: Writes use `wr_addr` = {channel, field}. Field 00 is control: bit 0 run, bit 1 bi-value, bits 4:2 prescale select. Field 01 is the primary constant. Field 10 is the capture register. Field 11 is ignored. A capture-register write takes priority over a capture in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | {channel, field} write address |
| wr_data | input | 16 | Write data |
| cap_pin | input | 2 | Asynchronous capture pins, one per channel |
| sw_cap | input | 2 | Software capture strobes, one per channel |
| cascade_en | input | 1 | Join both channels into a 32-bit counter |
| tc | output | 2 | Terminal-count pulses |
| count0 | output | 16 | Channel 0 count |
| count1 | output | 16 | Channel 1 count |
| cap0 | output | 16 | Channel 0 capture / alternate constant |
| cap1 | output | 16 | Channel 1 capture / alternate constant |

## Verification
The embedded properties check on every cycle the local rules of each channel:
- the count is frozen in STOP;
- a single decrement per tick;
- a one-cycle `tc`, with reload from the primary constant outside bi-value mode;
- alternation toggling on each bi-value reload;
- capture-register immunity in bi-value mode;
- capture of the live count;
- the minimum prescaler tick spacing.

Only the bench's scenarios can show the exact divide ratio for each select value, and the position of the synchronized pin capture in time. They also show the merging of a pin edge with a software strobe, the ignored address, and the 32-bit cascade stepping. These scenarios are compared against a behavioural model on every clock.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

    typedef enum logic [1:0] {
        CH_STOP = 2'd0,
        CH_LOAD = 2'd1,
        CH_RUN  = 2'd2
    } ch_state_e;

    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_BIV_BIT = 1;
    localparam int CTRL_SEL_LSB = 2;

    localparam logic [1:0] FLD_CTRL = 2'd0;
    localparam logic [1:0] FLD_PRIM = 2'd1;
    localparam logic [1:0] FLD_ALT  = 2'd2;

endpackage

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
    parameter int PRE_W = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] mask;

    // Low (sel+1) bits set: the tick fires once per 2^(sel+1) clocks
    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            mask[i] = (i <= int'(sel));
        end
    end

    assign tick = en & ((cnt_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    // R2: the fastest ratio is /2, so two ticks never touch
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/cbt_sync_edge.sv
module cbt_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] shf_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shf_q <= '0;
        end else begin
            shf_q <= {shf_q[DEPTH-2:0], pin};
        end
    end

    assign rise = shf_q[STAGES-1] & ~shf_q[STAGES];

    // R5: one detect per synchronized edge
    a_r5_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/cbt_channel.sv
module cbt_channel
    import cbt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic             wr_prim,
    input  logic             wr_alt,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             tick,
    input  logic             cap_evt,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cap_val,
    output logic             tc,
    output logic             wrap,
    output logic             active,
    output logic [SEL_W-1:0] sel
);
    ch_state_e        state_q, state_d;
    logic [CNT_W-1:0] count_q, prim_q, cap_q, rl_val;
    logic             tc_q, alt_q, bival_q;
    logic [SEL_W-1:0] sel_q;
    logic             reload;

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_STOP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_STOP: state_d = CH_STOP;
            CH_LOAD: if (tick) state_d = CH_RUN;
            CH_RUN:  state_d = CH_RUN;
            default: state_d = CH_STOP;
        endcase
        if (wr_ctrl) begin
            if (!wr_data[CTRL_RUN_BIT])  state_d = CH_STOP;
            else if (state_q == CH_STOP) state_d = CH_LOAD;
        end
    end

    // ---------------- outputs ----------------
    assign wrap   = tick && (state_q == CH_RUN) && (count_q == '0);
    assign reload = wrap || (tick && (state_q == CH_LOAD));
    assign rl_val = (bival_q && alt_q) ? cap_q : prim_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            tc_q    <= 1'b0;
            alt_q   <= 1'b0;
        end else begin
            tc_q <= wrap;
            if (reload)                          count_q <= rl_val;
            else if (tick && state_q == CH_RUN)  count_q <= count_q - 1'b1;
            if (!bival_q)    alt_q <= 1'b0;
            else if (reload) alt_q <= ~alt_q;
        end
    end

    // ---------------- configuration and capture ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prim_q  <= '0;
            cap_q   <= '0;
            bival_q <= 1'b0;
            sel_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                bival_q <= wr_data[CTRL_BIV_BIT];
                sel_q   <= wr_data[CTRL_SEL_LSB +: SEL_W];
            end
            if (wr_prim) prim_q <= wr_data;
            if (wr_alt)                    cap_q <= wr_data;
            else if (cap_evt && !bival_q)  cap_q <= count_q;
        end
    end

    assign count   = count_q;
    assign cap_val = cap_q;
    assign tc      = tc_q;
    assign active  = (state_q != CH_STOP);
    assign sel     = sel_q;

    // R3: a stopped channel keeps its count
    a_r3_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_STOP) |=> $stable(count_q));
    // R3: one step down per tick while running above zero
    a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state_q == CH_RUN && count_q != '0) |=> (count_q == $past(count_q) - 1'b1));
    // R4: the terminal-count pulse lasts one cycle
    a_r4_tc_single: assert property (@(posedge clk) disable iff (!rst_n)
        tc_q |=> !tc_q);
    // R4: outside bi-value the reload comes from the primary constant
    a_r4_reload_prim: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !bival_q && !wr_prim) |=> (count_q == $past(prim_q)));
    // R7: each bi-value reload swaps the source constant
    a_r7_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && bival_q) |=> (alt_q != $past(alt_q)));
    // R8: in bi-value mode only a write changes the capture register
    a_r8_cap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (bival_q && !wr_alt) |=> $stable(cap_q));
    // R5: a capture takes the live count
    a_r5_capture_live: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt && !bival_q && !wr_alt) |=> (cap_q == $past(count_q)));

endmodule

// File: rtl/capbi_timer.sv
module capbi_timer
    import cbt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8,
    parameter int SEL_W = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       cap_pin,
    input  logic [1:0]       sw_cap,
    input  logic             cascade_en,
    output logic [1:0]       tc,
    output logic [CNT_W-1:0] count0,
    output logic [CNT_W-1:0] count1,
    output logic [CNT_W-1:0] cap0,
    output logic [CNT_W-1:0] cap1
);
    localparam int NCH = 2;

    logic [NCH-1:0]   hit, pin_rise, cap_evt, pre_en, pre_tick, active;
    logic [SEL_W-1:0] sel0, sel1;
    logic [1:0]       fld;
    logic             tick0, tick1, wrap0, wrap1;

    assign fld = wr_addr[1:0];
    assign hit = {wr_en & wr_addr[2], wr_en & ~wr_addr[2]};

    // Cascade: channel 1's prescaler clocks channel 0, channel 0's is held
    assign pre_en[0] = ~cascade_en & active[0];
    assign pre_en[1] = cascade_en ? active[0] : active[1];
    assign tick0     = cascade_en ? pre_tick[1] : pre_tick[0];
    assign tick1     = cascade_en ? wrap0 : pre_tick[1];

    for (genvar g = 0; g < NCH; g++) begin : g_front
        cbt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (cap_pin[g]),
            .rise (pin_rise[g])
        );
        assign cap_evt[g] = pin_rise[g] | sw_cap[g];

        cbt_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (pre_en[g]),
            .sel  ((g == 0) ? sel0 : sel1),
            .tick (pre_tick[g])
        );
    end

    cbt_channel #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_ch0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_ctrl(hit[0] && fld == FLD_CTRL),
        .wr_prim(hit[0] && fld == FLD_PRIM),
        .wr_alt (hit[0] && fld == FLD_ALT),
        .wr_data(wr_data),
        .tick   (tick0),
        .cap_evt(cap_evt[0]),
        .count  (count0),
        .cap_val(cap0),
        .tc     (tc[0]),
        .wrap   (wrap0),
        .active (active[0]),
        .sel    (sel0)
    );

    cbt_channel #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_ch1 (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_ctrl(hit[1] && fld == FLD_CTRL),
        .wr_prim(hit[1] && fld == FLD_PRIM),
        .wr_alt (hit[1] && fld == FLD_ALT),
        .wr_data(wr_data),
        .tick   (tick1),
        .cap_evt(cap_evt[1]),
        .count  (count1),
        .cap_val(cap1),
        .tc     (tc[1]),
        .wrap   (wrap1),
        .active (active[1]),
        .sel    (sel1)
    );

    // R4: each reload event shows up on tc one edge later
    a_r4_wrap_tc0: assert property (@(posedge clk) disable iff (!rst_n)
        wrap0 |=> tc[0]);
    a_r4_wrap_tc1: assert property (@(posedge clk) disable iff (!rst_n)
        wrap1 |=> tc[1]);
    // R9: in cascade the upper channel moves only on a lower reload
    a_r9_upper_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade_en && !wrap0 && active[1]) |=> $stable(count1));

endmodule

// File: tb/capbi_timer_tb.sv
`timescale 1ns/1ps
module capbi_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  cap_pin = '0;
    logic [1:0]  sw_cap = '0;
    logic        cascade_en = 1'b0;
    logic [1:0]  tc;
    logic [15:0] count0, count1, cap0, cap1;

    int    n_cmp = 0, n_bad = 0, cyc = 0;
    string tag = "R1";
    bit    started = 0, done = 0;

    // behavioural model state (state: 0 stopped, 1 waiting first tick, 2 counting)
    int m_st[2], m_cnt[2], m_cap[2], m_prim[2], m_bv[2], m_sel[2];
    int m_alt[2], m_pre[2], m_s1[2], m_s2[2], m_s3[2], m_tc[2];

    always #4 clk = ~clk;

    capbi_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cap_pin(cap_pin), .sw_cap(sw_cap),
        .cascade_en(cascade_en), .tc(tc), .count0(count0), .count1(count1),
        .cap0(cap0), .cap1(cap1)
    );

    function automatic void model_reset();
        for (int c = 0; c < 2; c++) begin
            m_st[c] = 0; m_cnt[c] = 0; m_cap[c] = 0; m_prim[c] = 0; m_bv[c] = 0;
            m_sel[c] = 0; m_alt[c] = 0; m_pre[c] = 0; m_s1[c] = 0; m_s2[c] = 0;
            m_s3[c] = 0; m_tc[c] = 0;
        end
    endfunction

    function automatic void model_step();
        int en[2], tp[2], t[2];
        int w0;
        en[0] = (!cascade_en && m_st[0] != 0);
        en[1] = cascade_en ? (m_st[0] != 0) : (m_st[1] != 0);
        for (int c = 0; c < 2; c++) begin
            int msk = (1 << (m_sel[c] + 1)) - 1;
            tp[c] = en[c] && ((m_pre[c] & msk) == msk);
        end
        t[0] = cascade_en ? tp[1] : tp[0];
        w0   = t[0] && m_st[0] == 2 && m_cnt[0] == 0;
        t[1] = cascade_en ? w0 : tp[1];
        for (int c = 0; c < 2; c++) begin
            int wr  = wr_en && (int'(wr_addr[2]) == c);
            int fld = int'(wr_addr[1:0]);
            int cev = (m_s2[c] && !m_s3[c]) || sw_cap[c];
            int rl  = t[c] && (m_st[c] == 1 || (m_st[c] == 2 && m_cnt[c] == 0));
            int ncnt = m_cnt[c], nst = m_st[c], ncap = m_cap[c], nalt;
            if (rl) ncnt = (m_bv[c] && m_alt[c]) ? m_cap[c] : m_prim[c];
            else if (t[c] && m_st[c] == 2) ncnt = (m_cnt[c] - 1) & 16'hFFFF;
            nalt = m_bv[c] ? (rl ? !m_alt[c] : m_alt[c]) : 0;
            if (m_st[c] == 1 && t[c]) nst = 2;
            if (wr && fld == 0) begin
                if (!wr_data[0]) nst = 0;
                else if (m_st[c] == 0) nst = 1;
            end
            if (wr && fld == 2) ncap = wr_data;
            else if (cev && !m_bv[c]) ncap = m_cnt[c];
            m_tc[c] = t[c] && m_st[c] == 2 && m_cnt[c] == 0;
            if (wr && fld == 0) begin
                m_bv[c]  = wr_data[1];
                m_sel[c] = int'(wr_data[4:2]);
            end
            if (wr && fld == 1) m_prim[c] = wr_data;
            m_pre[c] = en[c] ? ((m_pre[c] + 1) & 255) : 0;
            m_s3[c] = m_s2[c]; m_s2[c] = m_s1[c]; m_s1[c] = cap_pin[c];
            m_cnt[c] = ncnt; m_st[c] = nst; m_cap[c] = ncap; m_alt[c] = nalt;
        end
    endfunction

    always @(posedge clk) begin
        started <= 1'b1;
        cyc <= cyc + 1;
        if (!rst_n) model_reset();
        else model_step();
    end

    task automatic chk(string sig, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", tag, sig, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            chk("count0", count0, m_cnt[0]);
            chk("count1", count1, m_cnt[1]);
            chk("cap0", cap0, m_cap[0]);
            chk("cap1", cap1, m_cap[1]);
            chk("tc0", tc[0], m_tc[0]);
            chk("tc1", tc[1], m_tc[1]);
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 100000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        model_reset();
        idle(3);
        rst_n = 1'b1;
        tag = "R1"; idle(3);                      // reset values on all outputs
        tag = "R10";
        wr(3'd1, 16'd5);                          // channel 0 primary
        wr(3'd3, 16'hBEEF);                       // field 11: ignored
        wr(3'd2, 16'h0042);                       // capture register written
        idle(2);
        tag = "R3"; wr(3'd0, 16'h0001); idle(40); // run, /2
        tag = "R4"; idle(20);
        tag = "R2";
        wr(3'd0, 16'h0001 | (16'd2 << 2)); idle(100);   // /8
        wr(3'd5, 16'd3);
        wr(3'd4, 16'h0001 | (16'd3 << 2)); idle(200);   // channel 1 /16
        wr(3'd4, 16'h0001 | (16'd7 << 2)); idle(1100);  // /256
        tag = "R5";
        cap_pin[0] = 1'b1; idle(4); cap_pin[0] = 1'b0; idle(10);
        cap_pin[1] = 1'b1; idle(4); cap_pin[1] = 1'b0; idle(10);
        tag = "R6";
        sw_cap[0] = 1'b1; idle(1); sw_cap[0] = 1'b0; idle(6);
        cap_pin[0] = 1'b1; idle(2); sw_cap[0] = 1'b1; idle(1); sw_cap[0] = 1'b0;
        idle(3); cap_pin[0] = 1'b0; idle(8);
        tag = "R10";
        @(negedge clk); wr_en = 1'b1; wr_addr = 3'd2; wr_data = 16'h0123; sw_cap[0] = 1'b1;
        @(negedge clk); wr_en = 1'b0; sw_cap[0] = 1'b0; idle(4);
        tag = "R7";
        wr(3'd2, 16'd6); wr(3'd1, 16'd3);
        wr(3'd0, 16'h0003); idle(80);
        tag = "R8";
        sw_cap[0] = 1'b1; idle(3); sw_cap[0] = 1'b0;
        cap_pin[0] = 1'b1; idle(4); cap_pin[0] = 1'b0; idle(10);
        tag = "R7"; wr(3'd0, 16'h0001); idle(30);   // bi-value cleared
        tag = "R3"; wr(3'd0, 16'h0000); idle(20);   // stop freezes
        tag = "R9";
        wr(3'd4, 16'h0000);
        cascade_en = 1'b1;
        wr(3'd1, 16'd2); wr(3'd5, 16'd1);
        wr(3'd4, 16'h0001); wr(3'd0, 16'h0001);
        idle(150);
        cascade_en = 1'b0; idle(20);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule